// File: doc/BRIEF.md
# Embedded-Clock Frame Aligner with False-Lock Guard

This block sits on the receive side of a serial link whose frames carry their own clock. It takes a bitstream that has already been recovered to one sample per bit, qualified by a valid strobe. Each 12-bit frame has the following layout, in the order the bits are sent:

- a high clock bit;
- data bits 0 through 9;
- a low clock bit.

The only reliable frame boundary is therefore the low-to-high edge from one frame's closing bit to the next frame's opening bit. The aligner keeps a per-position count of how many consecutive frames showed a rising edge at each bit position. It declares lock on a position that has shown the edge for a set number of frames. Once locked, it emits each frame's 10 data bits as a parallel word together with a single-cycle strobe.

Repeating data can mimic the clock edge, for example a fixed alternating pattern inside the data field. When that happens, several positions keep their edge frame after frame, and any of them could be the boundary. The aligner withholds lock while a second surviving position sits where a rising edge into data bits 1 to 8 would fall, relative to the candidate. It resumes as soon as the data changes. An edge into data bit 9 is never treated as a competitor.

An output enable gates the word and strobe without touching lock. Driving both the enable and the power input low puts the block to sleep and wipes the search.

Top module: `fa_frame_align`

## Requirements
- R1: While locked, after the closing bit of each frame is sampled, `stb_o` is high for exactly one cycle and `word_o` bit k equals data bit k of that frame. Data bit k is the (k+2)-th bit of the frame.
- R2: With clean frames, `lock_o` rises in the cycle after the closing bit of the 8th consecutive frame with a rising edge at the same position. It is still low after the 7th.
- R3: While another position lying 2 to 9 bits after the candidate also shows a rising edge for 8 consecutive frames, `lock_o` stays low. An alternating 0/1 pattern in data bits 0 to 8 is one such case.
- R4: A rising edge into data bit 9 (10 bits after the boundary), repeated for any number of frames, neither blocks nor drops lock.
- R5: When a competing pattern stops, lock is reached at the end of the first frame in which the competing positions show no edge.
- R6: If a competing position builds up while locked, `lock_o` falls and no strobe is issued for the frame in which it reaches 8. Lock and strobes return at the end of the first frame without it.
- R7: A single frame without the boundary edge keeps lock. Two consecutive such frames drop lock, and a fresh 8-frame acquisition is then required.
- R8: While `oe_i` is low, `word_o` is all zeros and `stb_o` is low, and `lock_o` still shows the true lock state.
- R9: With `oe_i` and `pwr_en_i` both low, `lock_o` is low from the next cycle on and the search is cleared. `pwr_en_i` low alone has no effect.
- R10: After reset, `lock_o`, `stb_o` and `word_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 1 | Sample on `in_bit_i` is a new bit |
| in_bit_i | input | 1 | Recovered serial bit |
| oe_i | input | 1 | Output enable for word and strobe |
| pwr_en_i | input | 1 | Power request; low together with `oe_i` low means sleep |
| word_o | output | FRAME_BITS-2 | Parallel data word, bit k = data bit k |
| stb_o | output | 1 | One-cycle word strobe |
| lock_o | output | 1 | Frame alignment established and free of competitors |

## Verification
The word capture at a frame's closing bit and the competitor hold can fall in the same cycle. This happens when a competing edge reaches its eighth frame within the frame that is about to be captured. The bench locks on clean frames, then forces a rising edge into data bit 2 for eight frames. After the seventh frame, a strobe with the right word and a high lock are expected. After the eighth, both lock and the strobe must be absent. One all-ones frame must then restore both. The bench repeats this for every initial bit offset of the stream relative to the internal frame counter.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic {ST_SEARCH, ST_LOCKED} fa_state_e;
endpackage

// File: rtl/fa_phase_tracker.sv
module fa_phase_tracker #(
  parameter int FRAME_BITS  = 12,
  parameter int LOCK_FRAMES = 8,
  localparam int PW = $clog2(FRAME_BITS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  vld_i,
  input  logic                  bit_i,
  output logic [PW-1:0]         phase_o,
  output logic                  trans_o,
  output logic [FRAME_BITS-1:0] surv_o
);
  localparam int CW = $clog2(LOCK_FRAMES + 1);

  logic [PW-1:0] phase_q;
  logic          prev_q;

  assign trans_o = vld_i & ~prev_q & bit_i;
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      prev_q  <= 1'b1;
    end else if (vld_i) begin
      prev_q  <= bit_i;
      phase_q <= (phase_q == PW'(FRAME_BITS - 1)) ? '0 : phase_q + 1'b1;
    end
  end

  // one run-length counter per bit position of the frame
  for (genvar p = 0; p < FRAME_BITS; p++) begin : g_pos
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            cnt_q <= '0;
      else if (clear_i)                       cnt_q <= '0;
      else if (vld_i && phase_q == PW'(p)) begin
        if (!trans_o)                         cnt_q <= '0;
        else if (cnt_q != CW'(LOCK_FRAMES))   cnt_q <= cnt_q + 1'b1;
      end
    end
    assign surv_o[p] = (cnt_q == CW'(LOCK_FRAMES));
  end
endmodule

// File: rtl/fa_rmt_judge.sv
module fa_rmt_judge #(
  parameter int FRAME_BITS = 12,
  localparam int DATA_W = FRAME_BITS - 2
) (
  input  logic [FRAME_BITS-1:0] surv_i,
  output logic [FRAME_BITS-1:0] conf_o,
  output logic [FRAME_BITS-1:0] valid_o
);
  // a competitor sits 2..DATA_W-1 bits after the candidate (edges into data 1..DATA_W-2)
  for (genvar p = 0; p < FRAME_BITS; p++) begin : g_cand
    logic c;
    always_comb begin
      c = 1'b0;
      for (int o = 2; o < DATA_W; o++) c |= surv_i[(p + o) % FRAME_BITS];
    end
    assign conf_o[p]  = c;
    assign valid_o[p] = surv_i[p] & ~c;
  end
endmodule

// File: rtl/fa_word_cap.sv
module fa_word_cap #(
  parameter int FRAME_BITS = 12,
  localparam int DATA_W = FRAME_BITS - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              bit_i,
  input  logic              cap_i,
  output logic [DATA_W-1:0] word_o,
  output logic              stb_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      word_o <= '0;
      stb_o  <= 1'b0;
    end else begin
      stb_o <= cap_i;
      if (vld_i) sh_q <= {sh_q[DATA_W-2:0], bit_i};
      // cap_i comes with the closing bit; sh_q[0] is data bit DATA_W-1
      if (cap_i)
        for (int j = 0; j < DATA_W; j++) word_o[j] <= sh_q[DATA_W-1-j];
    end
  end
endmodule

// File: rtl/fa_frame_align.sv
module fa_frame_align
  import fa_pkg::*;
#(
  parameter int FRAME_BITS  = 12,
  parameter int LOCK_FRAMES = 8,
  parameter int MISS_FRAMES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_vld_i,
  input  logic                  in_bit_i,
  input  logic                  oe_i,
  input  logic                  pwr_en_i,
  output logic [FRAME_BITS-3:0] word_o,
  output logic                  stb_o,
  output logic                  lock_o
);
  localparam int DATA_W = FRAME_BITS - 2;
  localparam int PW     = $clog2(FRAME_BITS);
  localparam int MW     = $clog2(MISS_FRAMES + 1);

  fa_state_e       state_q;
  logic [PW-1:0]   lock_pos_q, phase, cand, stop_ph;
  logic [MW-1:0]   miss_q;
  logic            trans, sleep, drop, clear, hold, cap, single, search_hit, at_lock;
  logic [FRAME_BITS-1:0] surv, conf, valid;
  logic [DATA_W-1:0]     word_q;
  logic                  stb_q;

  assign sleep = ~oe_i & ~pwr_en_i;

  fa_phase_tracker #(.FRAME_BITS(FRAME_BITS), .LOCK_FRAMES(LOCK_FRAMES)) u_trk (
    .clk_i, .rst_ni, .clear_i(clear), .vld_i(in_vld_i), .bit_i(in_bit_i),
    .phase_o(phase), .trans_o(trans), .surv_o(surv)
  );

  fa_rmt_judge #(.FRAME_BITS(FRAME_BITS)) u_jdg (
    .surv_i(surv), .conf_o(conf), .valid_o(valid)
  );

  // candidate whose closing bit is being sampled now
  assign cand    = (phase == PW'(FRAME_BITS - 1)) ? '0 : phase + 1'b1;
  assign stop_ph = (lock_pos_q == '0) ? PW'(FRAME_BITS - 1) : lock_pos_q - 1'b1;
  assign single  = ((valid & (valid - 1'b1)) == '0);

  assign search_hit = in_vld_i & valid[cand] & single;
  assign at_lock    = in_vld_i & (phase == lock_pos_q);
  assign drop       = (state_q == ST_LOCKED) & at_lock & ~trans &
                      (miss_q == MW'(MISS_FRAMES - 1));
  assign clear      = sleep | drop;
  assign hold       = conf[lock_pos_q];
  assign lock_o     = (state_q == ST_LOCKED) & ~hold;
  assign cap        = in_vld_i & lock_o & (phase == stop_ph) & ~sleep;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_SEARCH;
      lock_pos_q <= '0;
      miss_q     <= '0;
    end else if (sleep) begin
      state_q <= ST_SEARCH;
      miss_q  <= '0;
    end else if (state_q == ST_SEARCH) begin
      if (search_hit) begin
        state_q    <= ST_LOCKED;
        lock_pos_q <= cand;
        miss_q     <= '0;
      end
    end else if (drop) begin
      state_q <= ST_SEARCH;
      miss_q  <= '0;
    end else if (at_lock) begin
      miss_q <= trans ? '0 : miss_q + 1'b1;
    end
  end

  fa_word_cap #(.FRAME_BITS(FRAME_BITS)) u_cap (
    .clk_i, .rst_ni, .vld_i(in_vld_i), .bit_i(in_bit_i), .cap_i(cap),
    .word_o(word_q), .stb_o(stb_q)
  );

  assign word_o = oe_i ? word_q : '0;
  assign stb_o  = oe_i & stb_q;
endmodule

// File: rtl/fa_frame_align_chk.sv
module fa_frame_align_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_vld_i,
  input logic              oe_i,
  input logic              pwr_en_i,
  input logic [DATA_W-1:0] word_o,
  input logic              stb_o,
  input logic              lock_o
);
  p_stb_after_lock_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> $past(lock_o));

  p_stb_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);

  p_rise_on_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !$past(lock_o)) |-> $past(in_vld_i));

  p_fall_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_o && $past(lock_o)) |-> ($past(in_vld_i) || $past(!oe_i && !pwr_en_i)));

  p_oe_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (!stb_o && word_o == '0));

  p_sleep_unlock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_i && !pwr_en_i) |=> !lock_o);
endmodule

bind fa_frame_align fa_frame_align_chk #(.DATA_W(FRAME_BITS - 2)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_vld_i(in_vld_i), .oe_i(oe_i),
  .pwr_en_i(pwr_en_i), .word_o(word_o), .stb_o(stb_o), .lock_o(lock_o)
);

// File: tb/sim_fa_frame_align.sv
`timescale 1ns/1ps
module sim_fa_frame_align;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       in_vld_i = 1'b0, in_bit_i = 1'b0, oe_i = 1'b1, pwr_en_i = 1'b1;
  logic [9:0] word_o;
  logic       stb_o, lock_o;
  int         n_chk = 0, n_fail = 0;
  logic [9:0] lf = 10'h1A5;

  always #2.5 clk_i = ~clk_i;

  fa_frame_align u0 (
    .clk_i, .rst_ni, .in_vld_i, .in_bit_i, .oe_i, .pwr_en_i,
    .word_o, .stb_o, .lock_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    @(negedge clk_i);
    in_vld_i = 1'b1;
    in_bit_i = b;
  endtask

  task automatic idle();
    @(negedge clk_i);
    in_vld_i = 1'b0;
    #1;
  endtask

  // ends 1 ns after the negedge following the closing bit's sampling edge
  task automatic send_frame(input logic st, input logic [9:0] d);
    put_bit(st);
    for (int j = 0; j < 10; j++) put_bit(d[j]);
    put_bit(1'b0);
    idle();
  endtask

  task automatic frame_ok(input logic [9:0] d, input string req);
    send_frame(1'b1, d);
    chk(lock_o == 1'b1, req, "lock", int'(lock_o), 1);
    chk(stb_o == 1'b1, req, "strobe", int'(stb_o), 1);
    chk(word_o == d, req, "word", int'(word_o), int'(d));
  endtask

  task automatic lock_after(input int n, input string req);
    for (int i = 1; i <= n; i++) begin
      send_frame(1'b1, 10'h3FF);
      chk(lock_o == (i == n), req, "acquire", int'(lock_o), int'(i == n));
    end
  endtask

  task automatic run_offset(input int k);
    rst_ni = 1'b0; in_vld_i = 1'b0; oe_i = 1'b1; pwr_en_i = 1'b1;
    repeat (3) idle();
    rst_ni = 1'b1;
    idle();
    chk(lock_o == 1'b0 && stb_o == 1'b0 && word_o == '0, "R10", "reset",
        int'({lock_o, stb_o}), 0);
    for (int i = 0; i < k; i++) put_bit(1'b0);

    // alternating data bits 0..8 offer competing boundaries
    for (int i = 0; i < 10; i++) begin
      send_frame(1'b1, 10'h0AA);
      chk(lock_o == 1'b0, "R3", "stuck pattern", int'(lock_o), 0);
    end
    send_frame(1'b1, 10'h3FF);
    chk(lock_o == 1'b1, "R5", "lock after change", int'(lock_o), 1);

    for (int i = 0; i < 8; i++) begin
      if (i % 2 == 0) begin
        frame_ok(lf, "R1");
        lf = {lf[8:0], lf[9] ^ lf[6]};
      end else frame_ok(10'h3FF, "R1");
    end

    // rising edge into data bit 9 only
    frame_ok(10'h3FF, "R4");
    for (int i = 0; i < 10; i++) frame_ok(10'h2FF, "R4");

    // rising edge into data bit 2 builds up while locked
    frame_ok(10'h3FF, "R6");
    for (int i = 0; i < 7; i++) frame_ok(10'h3FD, "R6");
    send_frame(1'b1, 10'h3FD);
    chk(lock_o == 1'b0, "R6", "hold lock", int'(lock_o), 0);
    chk(stb_o == 1'b0, "R6", "hold strobe", int'(stb_o), 0);
    frame_ok(10'h3FF, "R6");

    // missing boundary edges
    send_frame(1'b0, 10'h3FF);
    chk(lock_o == 1'b1, "R7", "one miss", int'(lock_o), 1);
    frame_ok(10'h3FF, "R7");
    send_frame(1'b0, 10'h3FF);
    send_frame(1'b0, 10'h3FF);
    chk(lock_o == 1'b0, "R7", "two misses", int'(lock_o), 0);
    lock_after(8, "R2");

    // output enable
    oe_i = 1'b0;
    for (int i = 0; i < 2; i++) begin
      send_frame(1'b1, 10'h3FF);
      chk(stb_o == 1'b0 && word_o == '0, "R8", "gated outputs",
          int'({stb_o, word_o}), 0);
      chk(lock_o == 1'b1, "R8", "lock kept", int'(lock_o), 1);
    end
    oe_i = 1'b1;

    // power request alone
    pwr_en_i = 1'b0;
    frame_ok(10'h3FF, "R9");

    // sleep
    oe_i = 1'b0;
    idle();
    chk(lock_o == 1'b0, "R9", "sleep", int'(lock_o), 0);
    send_frame(1'b1, 10'h3FF);
    chk(lock_o == 1'b0, "R9", "asleep", int'(lock_o), 0);
    oe_i = 1'b1; pwr_en_i = 1'b1;
    lock_after(8, "R9");
  endtask

  initial begin
    for (int k = 1; k <= 12; k++) run_offset(k);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R10 watchdog act=200000 exp=<200000");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule